// File: doc/BRIEF.md
# Self-Clocked Serial Output Model for a No-Latency Converter

This block models the digital side of a converter with no pipeline latency that produces its own serial clock. A conversion runs for a fixed number of system clocks, standing in for the modulator and filter. When it ends, the block stores the 17-bit signed word on its parallel input and drops its busy flag. The host then lowers the active-low select. After a short fixed test delay, the block drives the serial clock itself and shifts out a 19-bit frame.

The frame ends in one of two ways. After its last bit the block starts the next conversion. If the host raises select part-way through, the frame is cut short and a conversion starts at once. If select is raised before the test delay expires, the block goes back to sleep and keeps the stored word for a later read.

There are four states: `ST_CONVERT`, `ST_SLEEP`, `ST_TEST_WAIT` and `ST_SHIFT`. They are linked by these transitions:
- count done: `ST_CONVERT` to `ST_SLEEP`
- select low: `ST_SLEEP` to `ST_TEST_WAIT`
- early release: `ST_TEST_WAIT` to `ST_SLEEP`
- delay done: `ST_TEST_WAIT` to `ST_SHIFT`
- frame done: `ST_SHIFT` to `ST_CONVERT`
- abort: `ST_SHIFT` to `ST_CONVERT`

Top module: `adc_serial_emu`

## Requirements
- R1: Reset sends the block to the conversion state with the conversion counter at zero. The serial clock is high there, and the output enable is low while select is high.
- R2: Each conversion lasts CONV_CYCLES system clocks. On its last clock the block stores `result_in`. The word sent by later reads is that stored value, even if `result_in` changes afterwards.
- R3: The frame has 19 bits and is sent MSB first. Bit 18 is the busy flag, which is 0 in a frame. Bit 17 is always 0. Bits 16..0 are the stored word: bit 16 is the sign and bit 0 is the LSB. The first bit is on `sdo_out` from the start of output, and each later bit appears at a falling edge of `sck_out`.
- R4: Output starts TEST_CYCLES = ceil(3.6 × OSC_DIV) clocks after the block enters the test-wait state. It enters that state one clock after select is seen low in sleep, and this covers select being low already when the conversion ends. If select goes high during the wait, the block returns to sleep with the stored word kept.
- R5: During output, `sck_out` starts low, and each low and each high phase lasts HALF_DIV clocks. Outside output, `sck_out` stays high.
- R6: When the high phase of the 19th rising edge ends, a new conversion begins: `sck_out` stays high and `sdo_out` is 1.
- R7: Select going high during output ends the frame and starts a conversion on the next clock.
- R8: `sdo_oe` is the inverse of `cs_n`. While enabled, `sdo_out` is 1 in conversion and 0 in sleep and test-wait.
- R9: Select has no effect during a conversion. Its length stays CONV_CYCLES whatever `cs_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| result_in | input | 17 | Signed conversion result, stored at the end of each conversion |
| sck_out | output | 1 | Serial clock generated by the block |
| sdo_out | output | 1 | Serial data / busy flag |
| sdo_oe | output | 1 | Output enable for `sdo_out`; low means high impedance |

## Verification
A behavioural reference model in the bench runs alongside the design and is compared every clock. The stimulus covers five patterns, each separating one behaviour from its neighbours:
- A plain read after the conversion separates the frame layout from the bit order.
- A read with select held low across the end of a conversion tests the automatic path from sleep into test-wait.
- An early release followed by a change of `result_in` shows that the stored word, not the live input, is what gets sent.
- An abort after a few clock edges separates an abandoned frame from a completed one.
- Select toggling during a conversion shows that the conversion length does not depend on select.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    typedef enum logic [1:0] {
        ST_CONVERT   = 2'd0,
        ST_SLEEP     = 2'd1,
        ST_TEST_WAIT = 2'd2,
        ST_SHIFT     = 2'd3
    } emu_state_t;

    localparam int FRAME_BITS = 19;
    localparam int WORD_BITS  = 17;

    // test delay of 3.6 oscillator periods, rounded up to whole system clocks
    function automatic int test_cycles(input int osc_div);
        return (36 * osc_div + 9) / 10;
    endfunction

endpackage

// File: rtl/adc_emu_timer.sv
module adc_emu_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + 1'b1;
    end

    p_count_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/adc_emu_sck_gen.sv
module adc_emu_sck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck_hi,
    output logic fall_tick
);
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [HW-1:0] half_cnt;
    logic          phase;
    logic          half_end;

    assign half_end  = (half_cnt == HW'(HALF_DIV - 1));
    assign sck_hi    = !run || phase;
    assign fall_tick = run && phase && half_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            phase    <= 1'b0;
        end else if (!run) begin
            half_cnt <= '0;
            phase    <= 1'b0;
        end else if (half_end) begin
            half_cnt <= '0;
            phase    <= !phase;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !half_end) |=> (!run || $stable(phase)));
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!run || !phase));
endmodule

// File: rtl/adc_emu_shifter.sv
module adc_emu_shifter
    import adc_emu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [WORD_BITS-1:0] word_in,
    input  logic                 start,
    input  logic                 step,
    output logic                 cur_bit,
    output logic                 last_bit
);
    localparam int IW = $clog2(FRAME_BITS);

    logic [WORD_BITS-1:0]  held;
    logic [IW-1:0]         idx;
    logic [FRAME_BITS-1:0] frame;

    // flag bit (low once data is ready), fixed zero, then the stored word
    assign frame    = {1'b0, 1'b0, held};
    assign cur_bit  = frame[idx];
    assign last_bit = (idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held <= '0;
        else if (capture) held <= word_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  idx <= IW'(FRAME_BITS - 1);
        else if (start)              idx <= IW'(FRAME_BITS - 1);
        else if (step && !last_bit)  idx <= idx - 1'b1;
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (held == $past(word_in)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(held));
    p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && !last_bit) |=> (idx == $past(idx) - 1'b1));
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
    import adc_emu_pkg::*;
#(
    parameter int CONV_CYCLES = 60,
    parameter int OSC_DIV     = 2,
    parameter int HALF_DIV    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic [WORD_BITS-1:0] result_in,
    output logic                 sck_out,
    output logic                 sdo_out,
    output logic                 sdo_oe
);
    localparam int TEST_CYCLES = test_cycles(OSC_DIV);
    localparam int CNT_MAX     = (CONV_CYCLES > TEST_CYCLES) ? CONV_CYCLES : TEST_CYCLES;
    localparam int CNT_W       = $clog2(CNT_MAX + 1);

    emu_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             conv_done, test_done;
    logic             sck_hi, fall_tick;
    logic             cur_bit, last_bit;
    logic             frame_done;

    assign conv_done  = (cnt == CNT_W'(CONV_CYCLES - 1));
    assign test_done  = (cnt == CNT_W'(TEST_CYCLES - 1));
    assign frame_done = fall_tick && last_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CONVERT;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CONVERT:   if (conv_done)  nxt = ST_SLEEP;
            ST_SLEEP:     if (!cs_n)      nxt = ST_TEST_WAIT;
            ST_TEST_WAIT: if (cs_n)       nxt = ST_SLEEP;
                          else if (test_done) nxt = ST_SHIFT;
            ST_SHIFT:     if (cs_n || frame_done) nxt = ST_CONVERT;
            default:      nxt = ST_CONVERT;
        endcase
    end

    adc_emu_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (nxt != state),
        .count (cnt)
    );

    adc_emu_sck_gen #(.HALF_DIV(HALF_DIV)) i_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state == ST_SHIFT),
        .sck_hi    (sck_hi),
        .fall_tick (fall_tick)
    );

    adc_emu_shifter i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (state == ST_CONVERT && conv_done),
        .word_in  (result_in),
        .start    (state == ST_TEST_WAIT),
        .step     (state == ST_SHIFT && fall_tick),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    // outputs
    always_comb begin
        sck_out = sck_hi;
        sdo_oe  = !cs_n;
        unique case (state)
            ST_CONVERT:   sdo_out = 1'b1;
            ST_SLEEP:     sdo_out = 1'b0;
            ST_TEST_WAIT: sdo_out = 1'b0;
            ST_SHIFT:     sdo_out = cur_bit;
            default:      sdo_out = 1'b1;
        endcase
    end

    p_conv_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && !conv_done) |=> (state == ST_CONVERT));
    p_early_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TEST_WAIT && cs_n) |=> (state == ST_SLEEP));
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && cs_n) |=> (state == ST_CONVERT));
    p_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && frame_done) |=> (state == ST_CONVERT && sck_out));
    p_sleep_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !cs_n) |=> (state == ST_TEST_WAIT));
endmodule

// File: tb/test_adc_serial_emu.sv
`timescale 1ns/1ps
module test_adc_serial_emu;
    localparam int CONV = 60;
    localparam int OSCD = 2;
    localparam int HALF = 2;
    localparam int TEST = 8;   // ceil(3.6 * 2)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [16:0] result_in = '0;
    logic        sck_out, sdo_out, sdo_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    adc_serial_emu #(.CONV_CYCLES(CONV), .OSC_DIV(OSCD), .HALF_DIV(HALF)) i_adc_serial_emu (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .result_in(result_in),
        .sck_out(sck_out), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: 0 convert, 1 sleep, 2 test wait, 3 shifting
    int m_st, m_cnt, m_half, m_ph, m_bit;
    logic [16:0] m_held;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_half = 0; m_ph = 0; m_bit = 18; m_held = '0;
        end else begin
            case (m_st)
                0: if (m_cnt == CONV - 1) begin m_st = 1; m_held = result_in; m_cnt = 0; end
                   else m_cnt++;
                1: if (!cs_n) begin m_st = 2; m_cnt = 0; end
                2: if (cs_n) m_st = 1;
                   else if (m_cnt == TEST - 1) begin m_st = 3; m_half = 0; m_ph = 0; m_bit = 18; m_cnt = 0; end
                   else m_cnt++;
                default: if (cs_n) begin m_st = 0; m_cnt = 0; end
                   else if (m_half == HALF - 1) begin
                       m_half = 0;
                       if (m_ph == 0) m_ph = 1;
                       else begin
                           m_ph = 0;
                           if (m_bit == 0) begin m_st = 0; m_cnt = 0; end
                           else m_bit--;
                       end
                   end else m_half++;
            endcase
        end
    end

    function automatic logic model_sdo();
        logic [18:0] fr;
        fr = {2'b00, m_held};
        case (m_st)
            0: return 1'b1;
            1, 2: return 1'b0;
            default: return fr[m_bit];
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 sck", sck_out, (m_st != 3 || m_ph == 1));
            check("R8 oe", sdo_oe, !cs_n);
            if (!cs_n)
                check(m_st == 0 ? "R9 sdo conv" : (m_st == 3 ? "R3 sdo frame" : "R4 sdo wait"),
                      sdo_out, model_sdo());
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk); #1 cs_n = v;
    endtask

    // samples sdo at each rising sck; stops after nbits or on timeout
    task automatic capture(input int nbits, output logic [18:0] word);
        logic prev;
        int got;
        int guard;
        word = '0; got = 0; guard = 0;
        prev = sck_out;
        while (got < nbits && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (sck_out && !prev) begin
                word = {word[17:0], sdo_out};
                got++;
            end
            prev = sck_out;
        end
    endtask

    initial begin
        logic [18:0] w;
        wait_clk(3);
        // R1: reset state
        check("R1 sck idle", sck_out, 1'b1);
        check("R1 oe off", sdo_oe, 1'b0);
        #1 rst_n = 1'b1;

        // full read after conversion
        result_in = 17'h1A5C3;
        wait_clk(CONV + 5);
        set_cs(1'b0);
        capture(19, w);
        check("R3 full frame", w, {2'b00, 17'h1A5C3});
        wait_clk(HALF + 1);
        check("R6 busy after frame", sdo_out, 1'b1);
        check("R6 sck high after frame", sck_out, 1'b1);

        // early release keeps the word, live input ignored afterwards
        set_cs(1'b1);
        result_in = 17'h0F0F0;
        wait_clk(CONV + 10);
        result_in = 17'h13579;
        set_cs(1'b0);
        wait_clk(3);
        set_cs(1'b1);
        wait_clk(20);
        check("R4 no clock after early release", sck_out, 1'b1);
        set_cs(1'b0);
        capture(19, w);
        check("R2 held word after release", w, {2'b00, 17'h0F0F0});

        // select held low through the next conversion
        result_in = 17'h00001;
        capture(19, w);
        check("R4 read with select already low", w, {2'b00, 17'h00001});

        // abort in mid frame
        set_cs(1'b1);
        result_in = 17'h1FFFF;
        wait_clk(CONV + 5);
        set_cs(1'b0);
        capture(5, w);
        set_cs(1'b1);
        set_cs(1'b0);
        check("R7 converting after abort", sdo_out, 1'b1);
        check("R7 sck high after abort", sck_out, 1'b1);

        // select toggles during conversion
        for (int k = 0; k < 6; k++) begin
            set_cs(1'b1);
            wait_clk(2);
            set_cs(1'b0);
            wait_clk(3);
        end
        capture(19, w);
        check("R9 read after toggled conversion", w, {2'b00, 17'h1FFFF});
        set_cs(1'b1);
        wait_clk(10);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule